// File: doc/BRIEF.md
# Dual H-Bridge Fault and Power-Mode Supervisor

This block is the supervisory logic that sits between the protection sensors of a two-bridge motor driver and its power stage. It watches an active-low reset, an active-low sleep request, one persistent-overcurrent flag per bridge, an overtemperature flag and an undervoltage flag. From these it decides which bridges must be switched off, whether the charge pump and regulator may run, and whether control inputs are currently being ignored. It also drives an active-low fault indication and a ready flag.

Each fault class has its own recovery rule. An overcurrent on a bridge latches that bridge off until a reset or a supply dip. Overtemperature shuts every bridge and the pump down, pulls the fault line low, and clears itself as soon as the flag drops. Undervoltage shuts everything down without any fault indication and wipes the internal state. Leaving sleep, undervoltage or reset starts a fixed wake-up delay, and no bridge is driven until it has run out.

Top module: `motor_supervisor`

## Requirements
- R1: While `rst_n` is low, every `bridge_off` bit is 1, `ready` is 0, `inputs_ignore` is 1, `pump_en` is 0 and `fault_n` is 1, whatever the flag inputs are.
- R2: `ready` rises exactly `WAKE_CYCLES` rising clock edges after the last edge at which reset, sleep or undervoltage was still active. While `ready` is 0 every `bridge_off` bit is 1, and overcurrent flags seen in that window are not latched.
- R3: `ocp_persist[i]` high at a rising edge where `ready` is 1 and the block is awake latches bridge i: from that edge `bridge_off[i]` is 1 and `fault_n` is 0, and both stay so after the flag drops, until `rst_n` goes low or `uv_flag` is seen at an edge.
- R4: An overcurrent latch on one bridge leaves the other bridge's `bridge_off` bit at 0 and `pump_en` at 1.
- R5: While awake with `ot_flag` high, all `bridge_off` bits are 1, `fault_n` is 0 and `pump_en` is 0, in the same cycle; when `ot_flag` drops, bridges without a latched overcurrent resume and `fault_n` returns to 1 in the same cycle.
- R6: While `uv_flag` is high, `pump_en` is 0 and all bridges are off; from the first edge that sees it, `fault_n` is 1 even with `ot_flag` high, all overcurrent latches are cleared and the wake-up delay restarts.
- R7: While `sleep_n` is low, all bridges are off, `pump_en` is 0, `ot_flag` does not pull `fault_n` low, overcurrent flags are not latched, and `ready` falls at the next edge.
- R8: `inputs_ignore` is 1 exactly when `rst_n` is low, `sleep_n` is low or `uv_flag` is high, with no delay.
- R9: When ready, awake, with no overtemperature and no latched overcurrent, all `bridge_off` bits are 0, `pump_en` is 1 and `fault_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Active-low reset; asynchronous clear of all state |
| sleep_n | input | 1 | Active-low low-power request |
| ocp_persist | input | NB | Per-bridge persistent overcurrent flag |
| ot_flag | input | 1 | Die overtemperature flag, hysteresis applied upstream |
| uv_flag | input | 1 | Supply undervoltage flag |
| bridge_off | output | NB | Per-bridge force-off (all switches open) |
| pump_en | output | 1 | Charge pump and regulator enable |
| inputs_ignore | output | 1 | Control inputs are being disregarded |
| ready | output | 1 | Wake-up delay has expired |
| fault_n | output | 1 | Active-low fault indication (open-drain pull-down model) |

## Verification
Results fall into two timing classes. `pump_en`, `inputs_ignore`, and the overtemperature and sleep effects on `bridge_off` and `fault_n` follow the inputs in the same cycle, so the bench checks them one time unit after driving, before any clock edge. Overcurrent latching, latch clearing by undervoltage and the fall of `ready` appear after the next rising edge, and `ready` rises after exactly `WAKE_CYCLES` edges; the bench drives inputs shortly after an edge and counts edges, checking `ready` one edge before and at the expiry edge.

// File: rtl/motor_sup_pkg.sv
package motor_sup_pkg;

  // Block is awake: out of reset, out of sleep and supply healthy.
  function automatic logic is_awake(input logic rst_n, input logic sleep_n,
                                    input logic uv);
    return rst_n & sleep_n & ~uv;
  endfunction

  // A bridge is forced off by any global stop or by its own latch.
  function automatic logic bridge_kill(input logic awake, input logic rdy,
                                       input logic ot, input logic latched);
    return ~awake | ~rdy | ot | latched;
  endfunction

endpackage

// File: rtl/motor_wake_timer.sv
module motor_wake_timer #(
  parameter int WAKE_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic ready
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (hold)        cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LIMIT);
endmodule

// File: rtl/motor_ocp_latch_bank.sv
module motor_ocp_latch_bank #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          arm,
  input  logic [NB-1:0] ocp_persist,
  output logic [NB-1:0] latched
);
  for (genvar i = 0; i < NB; i++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    latched[i] <= 1'b0;
      else if (clr)                  latched[i] <= 1'b0;
      else if (arm && ocp_persist[i]) latched[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/motor_sup_decode.sv
module motor_sup_decode
  import motor_sup_pkg::*;
#(
  parameter int NB = 2
) (
  input  logic          awake,
  input  logic          ready,
  input  logic          ot_flag,
  input  logic [NB-1:0] latched,
  output logic [NB-1:0] bridge_off,
  output logic          pump_en,
  output logic          inputs_ignore,
  output logic          fault_n
);
  logic ot_live;
  assign ot_live       = awake & ot_flag;
  assign pump_en       = awake & ~ot_flag;
  assign inputs_ignore = ~awake;
  assign fault_n       = ~(|latched | ot_live);

  for (genvar i = 0; i < NB; i++) begin : g_off
    assign bridge_off[i] = bridge_kill(awake, ready, ot_flag, latched[i]);
  end
endmodule

// File: rtl/motor_supervisor.sv
module motor_supervisor
  import motor_sup_pkg::*;
#(
  parameter int NB          = 2,
  parameter int WAKE_CYCLES = 40000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_n,
  input  logic [NB-1:0] ocp_persist,
  input  logic          ot_flag,
  input  logic          uv_flag,
  output logic [NB-1:0] bridge_off,
  output logic          pump_en,
  output logic          inputs_ignore,
  output logic          ready,
  output logic          fault_n
);
  logic          awake;
  logic          wake_hold;
  logic          ocp_arm;
  logic [NB-1:0] ocp_latched;

  assign awake     = is_awake(rst_n, sleep_n, uv_flag);
  assign wake_hold = ~sleep_n | uv_flag;
  assign ocp_arm   = awake & ready;

  motor_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (wake_hold),
    .ready (ready)
  );

  motor_ocp_latch_bank #(.NB(NB)) u_ocp (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (uv_flag),
    .arm         (ocp_arm),
    .ocp_persist (ocp_persist),
    .latched     (ocp_latched)
  );

  motor_sup_decode #(.NB(NB)) u_dec (
    .awake         (awake),
    .ready         (ready),
    .ot_flag       (ot_flag),
    .latched       (ocp_latched),
    .bridge_off    (bridge_off),
    .pump_en       (pump_en),
    .inputs_ignore (inputs_ignore),
    .fault_n       (fault_n)
  );
endmodule

// File: rtl/motor_supervisor_chk.sv
module motor_supervisor_chk #(
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sleep_n,
  input logic [NB-1:0] ocp_persist,
  input logic          ot_flag,
  input logic          uv_flag,
  input logic [NB-1:0] bridge_off,
  input logic          pump_en,
  input logic          inputs_ignore,
  input logic          ready,
  input logic          fault_n,
  input logic [NB-1:0] ocp_latched
);
  AST_NOT_READY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> &bridge_off); // R2

  AST_OCP_TRIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && sleep_n && !uv_flag && ocp_persist[0]) |=> bridge_off[0]); // R3

  AST_OCP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ocp_latched[0] && !uv_flag) |=> ocp_latched[0]); // R3

  AST_PUMP_SURVIVES_OCP: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && !uv_flag && !ot_flag) |-> pump_en); // R4

  AST_OT_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ot_flag && sleep_n && !uv_flag) |-> (!fault_n && !pump_en && &bridge_off)); // R5

  AST_UV_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(uv_flag) && uv_flag) |-> (fault_n && !pump_en && &bridge_off)); // R6

  AST_SLEEP_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> !ready); // R7

  AST_IGNORE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n || uv_flag) |-> inputs_ignore); // R8

  AST_IDLE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && sleep_n && !uv_flag && !ot_flag && ocp_latched == '0)
      |-> (bridge_off == '0 && fault_n)); // R9
endmodule

bind motor_supervisor motor_supervisor_chk #(.NB(NB)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_n       (sleep_n),
  .ocp_persist   (ocp_persist),
  .ot_flag       (ot_flag),
  .uv_flag       (uv_flag),
  .bridge_off    (bridge_off),
  .pump_en       (pump_en),
  .inputs_ignore (inputs_ignore),
  .ready         (ready),
  .fault_n       (fault_n),
  .ocp_latched   (ocp_latched)
);

// File: tb/motor_supervisor_bench.sv
`timescale 1ns/1ps
module motor_supervisor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 2;
  localparam int WAKE = 16;

  // {ocp[1:0], ot, exp_off[1:0], exp_fault_n, exp_pump}
  localparam logic [6:0] VEC [8] = '{
    7'b000_00_1_1, 7'b010_01_0_1, 7'b100_10_0_1, 7'b110_11_0_1,
    7'b001_11_0_0, 7'b011_11_0_0, 7'b101_11_0_0, 7'b111_11_0_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, sleep_n = 1'b1, ot_flag = 1'b0, uv_flag = 1'b0;
  logic [NB-1:0] ocp_persist = '0;
  logic [NB-1:0] bridge_off;
  logic pump_en, inputs_ignore, ready, fault_n;
  int n_run = 0, n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  motor_supervisor #(.NB(NB), .WAKE_CYCLES(WAKE)) u_motor_supervisor (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .ocp_persist(ocp_persist),
    .ot_flag(ot_flag), .uv_flag(uv_flag), .bridge_off(bridge_off),
    .pump_en(pump_en), .inputs_ignore(inputs_ignore), .ready(ready),
    .fault_n(fault_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic fresh_start();
    rst_n = 1'b0; sleep_n = 1'b1; uv_flag = 1'b0; ot_flag = 1'b0; ocp_persist = '0;
    tick(2);
    rst_n = 1'b1;
    tick(WAKE);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state with every flag active
    ot_flag = 1'b1; ocp_persist = 2'b11;
    tick(3);
    check("R1 bridge_off", 32'(bridge_off), 32'h3);
    check("R1 ready", 32'(ready), 32'h0);
    check("R1 inputs_ignore", 32'(inputs_ignore), 32'h1);
    check("R1 fault_n", 32'(fault_n), 32'h1);
    check("R1 pump_en", 32'(pump_en), 32'h0);

    // R2: wake-up delay counted in edges; overcurrent ignored meanwhile
    ot_flag = 1'b0; ocp_persist = 2'b01;
    rst_n = 1'b1;
    tick(WAKE - 1);
    check("R2 ready before expiry", 32'(ready), 32'h0);
    check("R2 bridges off while waking", 32'(bridge_off), 32'h3);
    ocp_persist = '0;
    tick(1);
    check("R2 ready at expiry", 32'(ready), 32'h1);
    check("R2 no latch from wake window", 32'(fault_n), 32'h1);
    check("R9 bridges run", 32'(bridge_off), 32'h0);
    check("R9 pump on", 32'(pump_en), 32'h1);

    // Table: R3 R4 R5 latch behaviour then overtemperature recovery
    for (int v = 0; v < 8; v++) begin
      fresh_start();
      ocp_persist = VEC[v][6:5];
      ot_flag     = VEC[v][4];
      tick(1);
      ocp_persist = '0;
      #1;
      check($sformatf("R3/R5 row%0d off", v), 32'(bridge_off), 32'(VEC[v][3:2]));
      check($sformatf("R3/R5 row%0d fault_n", v), 32'(fault_n), 32'(VEC[v][1]));
      check($sformatf("R4/R5 row%0d pump", v), 32'(pump_en), 32'(VEC[v][0]));
      ot_flag = 1'b0;
      #1;
      check($sformatf("R5 row%0d recover off", v), 32'(bridge_off), 32'(VEC[v][6:5]));
      check($sformatf("R5 row%0d recover fault_n", v), 32'(fault_n),
            32'(VEC[v][6:5] == 2'b00));
    end

    // R3: latch cleared by reset
    fresh_start();
    ocp_persist = 2'b10;
    tick(1);
    ocp_persist = '0;
    tick(3);
    check("R3 latch holds", 32'(fault_n), 32'h0);
    rst_n = 1'b0;
    #1;
    check("R3 reset clears latch", 32'(fault_n), 32'h1);

    // R7 R8: sleep
    fresh_start();
    sleep_n = 1'b0;
    #1;
    check("R7 sleep bridges off", 32'(bridge_off), 32'h3);
    check("R7 sleep pump off", 32'(pump_en), 32'h0);
    check("R8 sleep ignore", 32'(inputs_ignore), 32'h1);
    ot_flag = 1'b1; ocp_persist = 2'b11;
    #1;
    check("R7 sleep ot no fault", 32'(fault_n), 32'h1);
    tick(1);
    check("R7 ready falls", 32'(ready), 32'h0);
    tick(2);
    ot_flag = 1'b0; ocp_persist = '0; sleep_n = 1'b1;
    #1;
    check("R8 awake not ignoring", 32'(inputs_ignore), 32'h0);
    tick(WAKE);
    check("R7 ready after sleep", 32'(ready), 32'h1);
    check("R7 no latch from sleep", 32'(bridge_off), 32'h0);

    // R6: undervoltage is silent and clears latches
    ocp_persist = 2'b01;
    tick(1);
    ocp_persist = '0;
    check("R3 latched before uv", 32'(bridge_off), 32'h1);
    uv_flag = 1'b1; ot_flag = 1'b1;
    #1;
    check("R8 uv ignore", 32'(inputs_ignore), 32'h1);
    check("R6 uv pump off", 32'(pump_en), 32'h0);
    tick(1);
    check("R6 uv fault_n high", 32'(fault_n), 32'h1);
    check("R6 uv bridges off", 32'(bridge_off), 32'h3);
    check("R6 uv ready cleared", 32'(ready), 32'h0);
    uv_flag = 1'b0; ot_flag = 1'b0;
    tick(WAKE - 1);
    check("R6 wake restarts", 32'(ready), 32'h0);
    tick(1);
    check("R6 latch wiped", 32'(bridge_off), 32'h0);
    check("R6 fault clear after uv", 32'(fault_n), 32'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule